// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Aggregator

This block gathers a parameterised vector of level-sensitive interrupt lines into one request line for a processor. Every clock it captures the current input levels into a status register, so a status bit is high only while its line is high and drops as soon as the line drops; nothing is latched. An enable register, loaded by software, selects which captured lines may drive the request. The request is high whenever any bit is set in both registers.

Software reaches the block through a plain 32-bit register bus with a byte address, a write strobe with data, and a read strobe with registered read data. Only whole 32-bit words are transferred. The enable register can be read and written, and the status register can be read. Two further offsets accept writes and discard them, so drivers written for a richer controller can issue acknowledge and configuration writes without harm. Every other offset reads as zero and drops writes.

Top module: `irq_level_aggregator`

## Requirements
- R1: After reset the enable and status registers are zero, `irq_req` is low and `bus_rd_data` is zero, whatever the interrupt inputs do while reset is held.
- R2: Status bit i equals `irq_in[i]` as sampled at the most recent rising clock edge; a line that goes low clears its bit at the next edge.
- R3: `irq_req` is high exactly when the bitwise AND of the enable and status registers is nonzero, so an input change reaches `irq_req` right after the next rising edge.
- R4: A write to byte address 0x04 replaces the whole enable register with `bus_wr_data[NUM_SRC-1:0]`; write data bits at and above NUM_SRC are dropped and read back as zero.
- R5: A read strobe at address 0x04 returns the enable register on `bus_rd_data` right after the edge that accepts it; in any cycle after an edge with no read strobe, `bus_rd_data` is zero.
- R6: A read strobe at address 0x0C returns the status register in bits [NUM_SRC-1:0], with the upper bits zero, right after the accepting edge.
- R7: Writes to addresses 0x00 and 0x14 are accepted and change neither register.
- R8: A read at any address other than 0x04 and 0x0C (including unaligned ones such as 0x05) returns zero; a write at any address other than 0x04 changes no register.
- R9: An enable write changes `irq_req` right after the edge that accepts the write, not earlier.
- R10: When a read and a write to 0x04 arrive in the same cycle, the read returns the enable value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; interrupt inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level-sensitive interrupt lines, active high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data, valid the cycle after the strobe |
| irq_req | output | 1 | Combined interrupt request to the processor |

## Verification
A wrong status bit shows at the ports one edge after the input that should have set it, either as a wrong `irq_req` when that source is enabled or as a wrong word on a status read. A corrupted enable register shows the same way on the request line or on an enable read-back the cycle after the read strobe, and a write wrongly decoded at a sink or unused offset only becomes visible on the next enable read or a request that fails to follow the inputs. The bench therefore reads both registers often and compares `irq_req` after every edge against a model of both registers.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Byte offsets of the register map
  localparam logic [31:0] OFF_ACK_SINK = 32'h0000_0000;
  localparam logic [31:0] OFF_ENABLE   = 32'h0000_0004;
  localparam logic [31:0] OFF_STATUS   = 32'h0000_000C;
  localparam logic [31:0] OFF_CFG_SINK = 32'h0000_0014;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_SINK   = 2'd3
  } reg_sel_e;

  // Full-address compare; unaligned addresses never match
  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    if (a == OFF_ENABLE)                            return SEL_ENABLE;
    else if (a == OFF_STATUS)                       return SEL_STATUS;
    else if (a == OFF_ACK_SINK || a == OFF_CFG_SINK) return SEL_SINK;
    else                                            return SEL_NONE;
  endfunction

  // Mask with the low n bits set
  function automatic logic [31:0] src_fill(input int unsigned n);
    if (n >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << n) - 32'h1;
  endfunction

endpackage

// File: rtl/irqagg_pending.sv
module irqagg_pending #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_SRC-1:0] pend_q
);
  // Each bit tracks its line level; nothing is latched
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= irq_in[i];
    end
  end
endmodule

// File: rtl/irqagg_mask_reg.sv
module irqagg_mask_reg #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [31:0]        wr_data,
  output logic [NUM_SRC-1:0] mask_q
);
  if (NUM_SRC < 32) begin : g_drop
    logic unused_hi;
    assign unused_hi = ^wr_data[31:NUM_SRC];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_hit) mask_q <= wr_data[NUM_SRC-1:0];
  end
endmodule

// File: rtl/irqagg_combine.sv
module irqagg_combine #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] active_vec,
  output logic               irq_req
);
  assign active_vec = mask_q & pend_q;
  assign irq_req    = |active_vec;
endmodule

// File: rtl/irqagg_read_port.sv
module irqagg_read_port
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] pend_q,
  output logic [31:0]        rd_data
);
  logic [31:0] mask_w;
  logic [31:0] pend_w;

  if (NUM_SRC < 32) begin : g_pad
    assign mask_w = {{(32-NUM_SRC){1'b0}}, mask_q};
    assign pend_w = {{(32-NUM_SRC){1'b0}}, pend_q};
  end else begin : g_full
    assign mask_w = mask_q;
    assign pend_w = pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_ENABLE: rd_data <= mask_w;
        SEL_STATUS: rd_data <= pend_w;
        default:    rd_data <= '0;
      endcase
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/irq_level_aggregator.sv
module irq_level_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr_en,
  input  logic [31:0]        bus_wr_data,
  input  logic               bus_rd_en,
  output logic [31:0]        bus_rd_data,
  output logic               irq_req
);
  // Named internal events, visible to the bound checker
  reg_sel_e           sel;
  logic               mask_wr_hit;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] active_vec;

  assign sel         = decode_addr(32'(bus_addr));
  assign mask_wr_hit = bus_wr_en && (sel == SEL_ENABLE);

  irqagg_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .pend_q (pend_q)
  );

  irqagg_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (mask_wr_hit),
    .wr_data (bus_wr_data),
    .mask_q  (mask_q)
  );

  irqagg_combine #(.NUM_SRC(NUM_SRC)) u_combine (
    .mask_q     (mask_q),
    .pend_q     (pend_q),
    .active_vec (active_vec),
    .irq_req    (irq_req)
  );

  irqagg_read_port #(.NUM_SRC(NUM_SRC)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (bus_rd_en),
    .sel     (sel),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .rd_data (bus_rd_data)
  );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_in,
  input logic               bus_rd_en,
  input logic [31:0]        bus_wr_data,
  input reg_sel_e           sel,
  input logic               mask_wr_hit,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] active_vec,
  input logic [31:0]        bus_rd_data,
  input logic               irq_req
);
  logic armed;
  logic [31:0] mask_w;
  logic [31:0] pend_w;

  always_comb begin
    mask_w = '0;
    pend_w = '0;
    mask_w[NUM_SRC-1:0] = mask_q;
    pend_w[NUM_SRC-1:0] = pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_pend_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (pend_q == $past(irq_in)));

  assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (active_vec != '0));

  assert_irq_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |-> (active_vec == '0));

  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_hit |=> (mask_w == ($past(bus_wr_data) & src_fill(NUM_SRC))));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_hit |=> $stable(mask_q));

  assert_rd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> (bus_rd_data == 32'h0));

  assert_rd_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && sel == SEL_ENABLE) |=> (bus_rd_data == $past(mask_w)));

  assert_rd_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && sel == SEL_STATUS) |=> (bus_rd_data == $past(pend_w)));

  assert_rd_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && sel != SEL_ENABLE && sel != SEL_STATUS) |=> (bus_rd_data == 32'h0));
endmodule

bind irq_level_aggregator irqagg_checker #(.NUM_SRC(NUM_SRC)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_in      (irq_in),
  .bus_rd_en   (bus_rd_en),
  .bus_wr_data (bus_wr_data),
  .sel         (sel),
  .mask_wr_hit (mask_wr_hit),
  .mask_q      (mask_q),
  .pend_q      (pend_q),
  .active_vec  (active_vec),
  .bus_rd_data (bus_rd_data),
  .irq_req     (irq_req)
);

// File: tb/irq_level_aggregator_test.sv
module irq_level_aggregator_test;
  localparam int unsigned N  = 16;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic [AW-1:0] bus_addr;
  logic          bus_wr_en;
  logic [31:0]   bus_wr_data;
  logic          bus_rd_en;
  logic [31:0]   bus_rd_data;
  logic          irq_req;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  logic        done     = 1'b0;

  logic [N-1:0] exp_mask = '0;
  logic [N-1:0] exp_pend = '0;

  always #4 clk = ~clk;  // 125 MHz

  irq_level_aggregator #(.NUM_SRC(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
    .bus_rd_data(bus_rd_data), .irq_req(irq_req)
  );

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    logic [31:0] v = 32'h0;
    if (a == 8'h04)      v[N-1:0] = exp_mask;
    else if (a == 8'h0C) v[N-1:0] = exp_pend;
    return v;
  endfunction

  function automatic logic model_irq();
    for (int i = 0; i < N; i++)
      if (exp_mask[i] && exp_pend[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, pass one rising edge, check
  task automatic cycle(input logic [N-1:0] irq, input logic wr, input logic rd,
                       input logic [AW-1:0] a, input logic [31:0] d, input string req);
    logic [31:0] exp_rd;
    logic [N-1:0] next_mask;
    exp_rd    = rd ? model_read(a) : 32'h0;
    next_mask = (wr && a == 8'h04) ? d[N-1:0] : exp_mask;
    irq_in = irq; bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wr_data = d;
    @(negedge clk);
    exp_pend = irq;
    exp_mask = next_mask;
    check(req, "bus_rd_data", bus_rd_data, exp_rd);
    check(req, "irq_req", {31'b0, irq_req}, {31'b0, model_irq()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] addrs [8];
    void'($urandom(32'd20240611));
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h05, 8'h0D};
    rst_n = 1'b0; irq_in = '1; bus_addr = 8'h04; bus_wr_en = 1'b0;
    bus_wr_data = '1; bus_rd_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state with inputs high and a read strobe held
    check("R1", "bus_rd_data in reset", bus_rd_data, 32'h0);
    check("R1", "irq_req in reset", {31'b0, irq_req}, 32'h0);
    rst_n = 1'b1;
    cycle('0, 1'b0, 1'b1, 8'h04, 0, "R1");
    cycle('0, 1'b0, 1'b1, 8'h0C, 0, "R1");

    // R4: full-width write, upper bits dropped
    cycle('0, 1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF, "R4");
    cycle('0, 1'b0, 1'b1, 8'h04, 0, "R4");
    // R5: idle cycle returns zero
    cycle('0, 1'b0, 1'b0, 8'h04, 0, "R5");
    // R3, R2, R6: input raises request, status reads back, then drops
    cycle(16'h0008, 1'b0, 1'b0, 8'h00, 0, "R3");
    cycle(16'h0008, 1'b0, 1'b1, 8'h0C, 0, "R6");
    cycle(16'h0000, 1'b0, 1'b1, 8'h0C, 0, "R2");
    // R7: sink writes change nothing
    cycle(16'h8001, 1'b1, 1'b0, 8'h00, 32'h0, "R7");
    cycle(16'h8001, 1'b1, 1'b0, 8'h14, 32'h0, "R7");
    cycle(16'h8001, 1'b0, 1'b1, 8'h04, 0, "R7");
    cycle(16'h8001, 1'b0, 1'b1, 8'h0C, 0, "R7");
    // R8: other offsets ignored on write, zero on read
    cycle('0, 1'b1, 1'b0, 8'h05, 32'h0, "R8");
    cycle('0, 1'b1, 1'b0, 8'h0C, 32'h0, "R8");
    cycle('0, 1'b1, 1'b0, 8'h08, 32'h0, "R8");
    foreach (addrs[i])
      if (addrs[i] != 8'h04 && addrs[i] != 8'h0C)
        cycle('0, 1'b0, 1'b1, addrs[i], 0, "R8");
    cycle('0, 1'b0, 1'b1, 8'h04, 0, "R8");
    // R9: enable write takes effect right after its edge
    cycle('0, 1'b1, 1'b0, 8'h04, 32'h0, "R9");
    cycle(16'h0020, 1'b0, 1'b0, 8'h00, 0, "R9");
    cycle(16'h0020, 1'b1, 1'b0, 8'h04, 32'h0000_0020, "R9");
    cycle(16'h0020, 1'b1, 1'b0, 8'h04, 32'h0000_0040, "R9");
    // R10: same-cycle read and write see the old enable value
    cycle(16'h0020, 1'b1, 1'b1, 8'h04, 32'h0000_1234, "R10");
    cycle(16'h0020, 1'b0, 1'b1, 8'h04, 0, "R10");

    // Random traffic
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] irq;
      logic [AW-1:0] a;
      int unsigned op;
      irq = N'($urandom) & N'($urandom);
      a   = addrs[$urandom % 8];
      op  = $urandom % 5;
      case (op)
        0: cycle(irq, 1'b1, 1'b0, 8'h04, $urandom, "R4");
        1: cycle(irq, 1'b0, 1'b1, 8'h04, 0, "R5");
        2: cycle(irq, 1'b0, 1'b1, 8'h0C, 0, "R6");
        3: cycle(irq, $urandom_range(0, 1) == 1, 1'b1, a, $urandom, "R8");
        default: cycle(irq, 1'b0, 1'b0, a, 0, "R3");
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule